// File: doc/BRIEF.md
# Interval counter channel

This block is one 16-bit down-counting timer channel. It comes with the byte-wide register port that a host uses to program it. The host reaches the channel through an 8-bit data bus, an active-low chip select, active-low read and write strobes, and a 2-bit address. One address value is the channel's own data port. Address 3 is the shared control register. All bus activity and counting run on a single system clock. A separate one-cycle tick input stands in for each edge of the counting clock. The GATE input and the OUT line are sampled and driven in the same clock domain.

A control byte chooses one of four counting behaviours: a one-time terminal-count output, a periodic rate pulse, a square wave, or a strobe started by a GATE edge. The same byte sets how the 16-bit count is moved over the 8-bit bus: low byte only, high byte only, or low then high. A control byte whose access field is zero does not reprogram the channel. It freezes a snapshot of the count instead, and the host can then read the snapshot byte by byte while counting carries on.

Top module: `pic_channel`

## Requirements
- R1: After reset, `out_q` is 1 and `rdata` is 0x00.
- R2: A control byte is accepted only when it is written to address 3 and bits 7-6 equal the channel number (CHAN_ID, 0 by default). In such a byte, bits 5-4 hold the access field and bits 3-1 the mode: 000 selects terminal count, 010 or 110 selects rate, 011 or 111 selects square wave, and 101 selects GATE-triggered strobe. A control byte with mode 001 or 100 is ignored entirely. Bit 0 is ignored, so counting is always binary.
- R3: With access field 01, one data-port write sets the count to {0x00, byte}. With 10, one write sets it to {byte, 0x00}. With 11, the first write gives the low byte and the second the high byte, and the count takes effect only after the second write. A count of 0 acts as 65536: the counter wraps from 0x0000 to 0xFFFF.
- R4: In terminal-count mode, accepting the control byte drives OUT low, and a completed count write keeps it low. The first tick after the count write loads N. OUT rises on the (N+1)-th tick and then stays high. Ticks with GATE low do not decrement, although a pending count is still loaded. OUT changes only in a cycle after a tick, a control byte or a count write.
- R5: In rate mode (GATE high), the first tick after the count write loads N. OUT is then low for exactly one tick interval in every N ticks, starting N-1 ticks after each load. The counter reloads itself on the following tick. While GATE is low, ticks leave the count unchanged and force OUT high.
- R6: In square-wave mode, OUT is high for ceil(N/2) tick intervals and low for floor(N/2), measured from the loading tick. A tick with GATE low forces OUT high and stops counting.
- R7: In strobe mode, a GATE rising edge arms the channel, and the next tick loads N. Exactly N ticks after that load, OUT goes low for one tick interval. OUT pulses once per trigger, and it stays high when there is no trigger.
- R8: A control byte with access field 00 for this channel latches the current count. Reads then return the latched bytes in the programmed order until all of them have been read. Counting continues meanwhile. A second latch command before the read-out is complete is ignored.
- R9: A data-port read returns a byte on `rdata` at the next clock edge. When no latch is pending, the byte comes from the live count: low byte first when the access field is 11.
- R10: Data writes to addresses other than the channel number, and control bytes naming another channel, have no effect.
- R11: In rate and square-wave modes, a count written while the channel is running takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one clock per access |
| wr_n | input | 1 | Write strobe, active low, one clock per access |
| addr | input | 2 | Port select; 3 is the control register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cnt_tick | input | 1 | One-cycle counting tick |
| gate | input | 1 | Gate / trigger input |
| out_q | output | 1 | Registered channel output |

## Verification
The bench builds the channel with its default parameters: an 8-bit bus, which gives a 16-bit count, and channel number 0. Under these settings a full square-wave period of 5000 ticks takes about ten thousand clocks, so the bench can measure one exactly. A high-byte-only load of 256 and the 0x0000-to-0xFFFF wrap are also cheap enough to check directly, rather than by scaling the count down. Channel number 0 leaves address 1, address 2 and control bytes naming channel 1 free, and the bench uses them as foreign targets for the checks that writes to other ports are ignored.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    MODE_TC     = 2'd0,
    MODE_RATE   = 2'd1,
    MODE_SQUARE = 2'd2,
    MODE_STROBE = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  // Returns {valid, mode} for the 3-bit mode field of a control byte.
  function automatic logic [2:0] decode_mode(input logic [2:0] f);
    case (f)
      3'b000:          return {1'b1, MODE_TC};
      3'b010, 3'b110:  return {1'b1, MODE_RATE};
      3'b011, 3'b111:  return {1'b1, MODE_SQUARE};
      3'b101:          return {1'b1, MODE_STROBE};
      default:         return {1'b0, MODE_TC};
    endcase
  endfunction
endpackage

// File: rtl/pic_bus_if.sv
module pic_bus_if
  import pic_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHAN_ID = 0,
  localparam int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [DATA_W-1:0] rdata,
  output mode_e             mode_q,
  output logic              cw_evt,
  output logic              cnt_evt,
  output logic [CNT_W-1:0]  reload_q
);
  localparam logic [1:0] SEL = 2'(CHAN_ID);
  localparam logic [1:0] CTRL_ADDR = 2'b11;

  acc_e              acc_q;
  logic              wr_hi_q, rd_hi_q, latched_q;
  logic [CNT_W-1:0]  lat_q;
  logic [DATA_W-1:0] lo_stage_q;

  logic             wr_ev, rd_ev, ctl_hit, data_wr, data_rd, rd_done;
  logic [2:0]       mode_dec;
  logic [CNT_W-1:0] src;
  logic [DATA_W-1:0] rd_byte;

  assign wr_ev    = !cs_n && !wr_n;
  assign rd_ev    = !cs_n && !rd_n;
  assign ctl_hit  = wr_ev && (addr == CTRL_ADDR) && (wdata[7:6] == SEL);
  assign data_wr  = wr_ev && (addr == SEL);
  assign data_rd  = rd_ev && (addr == SEL);
  assign mode_dec = decode_mode(wdata[3:1]);
  assign src      = latched_q ? lat_q : cur_cnt;

  // Byte chosen by the access field and the read pointer.
  always_comb begin
    rd_byte = src[DATA_W-1:0];
    rd_done = 1'b1;
    case (acc_q)
      ACC_HI:   rd_byte = src[CNT_W-1:DATA_W];
      ACC_BOTH: begin
        rd_byte = rd_hi_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
        rd_done = rd_hi_q;
      end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_TC;
      acc_q      <= ACC_BOTH;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      latched_q  <= 1'b0;
      lat_q      <= '0;
      lo_stage_q <= '0;
      reload_q   <= '0;
      rdata      <= '0;
      cw_evt     <= 1'b0;
      cnt_evt    <= 1'b0;
    end else begin
      cw_evt  <= 1'b0;
      cnt_evt <= 1'b0;
      if (ctl_hit) begin
        if (wdata[5:4] == ACC_LATCH) begin
          if (!latched_q) begin
            lat_q     <= cur_cnt;
            latched_q <= 1'b1;
            rd_hi_q   <= 1'b0;
          end
        end else if (mode_dec[2]) begin
          mode_q    <= mode_e'(mode_dec[1:0]);
          acc_q     <= acc_e'(wdata[5:4]);
          wr_hi_q   <= 1'b0;
          rd_hi_q   <= 1'b0;
          latched_q <= 1'b0;
          cw_evt    <= 1'b1;
        end
      end
      if (data_wr) begin
        case (acc_q)
          ACC_LO: begin
            reload_q <= {{DATA_W{1'b0}}, wdata};
            cnt_evt  <= 1'b1;
          end
          ACC_HI: begin
            reload_q <= {wdata, {DATA_W{1'b0}}};
            cnt_evt  <= 1'b1;
          end
          ACC_BOTH: begin
            if (!wr_hi_q) begin
              lo_stage_q <= wdata;
              wr_hi_q    <= 1'b1;
            end else begin
              reload_q <= {wdata, lo_stage_q};
              wr_hi_q  <= 1'b0;
              cnt_evt  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (data_rd) begin
        rdata <= rd_byte;
        if (acc_q == ACC_BOTH) rd_hi_q <= !rd_hi_q;
        if (rd_done) latched_q <= 1'b0;
      end
    end
  end

  // R8: a pending snapshot stays frozen until it is read or the channel is reprogrammed
  assert_latch_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !data_rd && !ctl_hit) |=> (latched_q && $stable(lat_q)));

  // R10: a control byte naming another channel leaves the mode untouched
  assert_foreign_ctrl_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && addr == CTRL_ADDR && wdata[7:6] != SEL) |=> $stable(mode_q));
endmodule

// File: rtl/pic_count_engine.sv
module pic_count_engine
  import pic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  mode_e            mode,
  input  logic             cw_evt,
  input  logic             cnt_evt,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             out_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic pend_q, run_q, trig_q, gate_q;
  logic gate_rise;
  logic [CNT_W:0]   span, hi_sum;
  logic [CNT_W-1:0] hi_len, lo_len;

  assign gate_rise = gate && !gate_q;
  // Zero count stands for 2**CNT_W; split it into the two half periods.
  assign span   = (reload == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, reload};
  assign hi_sum = span + 1'b1;
  assign hi_len = hi_sum[CNT_W:1];
  assign lo_len = (span[CNT_W:1] == '0) ? ONE : span[CNT_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      out_q  <= 1'b1;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      trig_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cw_evt) begin
        out_q  <= (mode == MODE_TC) ? 1'b0 : 1'b1;
        pend_q <= 1'b0;
        run_q  <= 1'b0;
        trig_q <= 1'b0;
      end else begin
        if (tick) begin
          case (mode)
            MODE_TC: begin
              if (pend_q) begin
                cnt_q  <= reload;
                pend_q <= 1'b0;
                run_q  <= 1'b1;
              end else if (run_q && gate) begin
                cnt_q <= cnt_q - ONE;
                if (cnt_q == ONE) out_q <= 1'b1;
              end
            end
            MODE_RATE: begin
              if (!gate) out_q <= 1'b1;
              else if (pend_q) begin
                cnt_q  <= reload;
                pend_q <= 1'b0;
                run_q  <= 1'b1;
                out_q  <= 1'b1;
              end else if (run_q) begin
                if (cnt_q == ONE) begin
                  cnt_q <= reload;
                  out_q <= 1'b1;
                end else begin
                  cnt_q <= cnt_q - ONE;
                  if (cnt_q == TWO) out_q <= 1'b0;
                end
              end
            end
            MODE_SQUARE: begin
              if (!gate) out_q <= 1'b1;
              else if (pend_q) begin
                cnt_q  <= hi_len;
                pend_q <= 1'b0;
                run_q  <= 1'b1;
                out_q  <= 1'b1;
              end else if (run_q) begin
                if (cnt_q == ONE) begin
                  cnt_q <= out_q ? lo_len : hi_len;
                  out_q <= !out_q;
                end else begin
                  cnt_q <= cnt_q - ONE;
                end
              end
            end
            default: begin
              if (trig_q) begin
                cnt_q  <= reload;
                trig_q <= 1'b0;
                run_q  <= 1'b1;
                out_q  <= 1'b1;
              end else begin
                cnt_q <= cnt_q - ONE;
                if (run_q && cnt_q == ONE) begin
                  out_q <= 1'b0;
                  run_q <= 1'b0;
                end else begin
                  out_q <= 1'b1;
                end
              end
            end
          endcase
        end
        if (gate_rise && mode == MODE_STROBE) trig_q <= 1'b1;
        if (cnt_evt) begin
          if (mode == MODE_TC) begin
            pend_q <= 1'b1;
            out_q  <= 1'b0;
          end else if (mode != MODE_STROBE && !run_q) begin
            pend_q <= 1'b1;
          end
        end
      end
    end
  end

  // R4: a completed count write in terminal-count mode leaves OUT low
  assert_tc_write_drops_out_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TC && cnt_evt && !cw_evt) |=> !out_q);

  // R4: OUT moves only after a tick, a control byte or a count write
  assert_out_steps_on_events_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cw_evt && !cnt_evt) |=> $stable(out_q));

  // R5: the rate-mode low pulse lasts a single tick interval
  assert_rate_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RATE && tick && !out_q && !cw_evt) |=> out_q);

  // R6: a tick with GATE low in square-wave mode forces OUT high
  assert_square_gate_high_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SQUARE && tick && !gate && !cw_evt) |=> out_q);

  // R7: the strobe pulse lasts a single tick interval
  assert_strobe_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STROBE && tick && !out_q && !cw_evt) |=> out_q);
endmodule

// File: rtl/pic_channel.sv
module pic_channel
  import pic_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cnt_tick,
  input  logic              gate,
  output logic              out_q
);
  localparam int CNT_W = 2 * DATA_W;

  mode_e            mode;
  logic             cw_evt, cnt_evt;
  logic [CNT_W-1:0] reload, cnt;

  pic_bus_if #(.DATA_W(DATA_W), .CHAN_ID(CHAN_ID)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .cur_cnt(cnt), .rdata(rdata),
    .mode_q(mode), .cw_evt(cw_evt), .cnt_evt(cnt_evt), .reload_q(reload)
  );

  pic_count_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .tick(cnt_tick), .gate(gate), .mode(mode),
    .cw_evt(cw_evt), .cnt_evt(cnt_evt), .reload(reload),
    .cnt_q(cnt), .out_q(out_q)
  );
endmodule

// File: tb/pic_channel_bench.sv
module pic_channel_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cnt_tick = 1'b0;
  logic       gate = 1'b1;
  logic       out_q;

  int vectors = 0;
  int miscomp = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = !clk;

  pic_channel u_pic_channel (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cnt_tick(cnt_tick),
    .gate(gate), .out_q(out_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscomp++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk); d = rdata; cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_tick = 1'b1;
      @(negedge clk); cnt_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 out after reset", out_q, 1);
    chk("R1 rdata after reset", rdata, 8'h00);
  endtask

  task automatic t_term_count();
    bus_wr(2'd3, 8'h30);
    chk("R4 control drops out", out_q, 0);
    bus_wr(2'd0, 8'h05); bus_wr(2'd0, 8'h00);
    chk("R4 out low after count", out_q, 0);
    ticks(5);
    chk("R4 out low at tick N", out_q, 0);
    ticks(1);
    chk("R4 out high at tick N+1", out_q, 1);
    ticks(3);
    chk("R4 out stays high", out_q, 1);
    bus_wr(2'd1, 8'h09);
    chk("R10 write to addr 1 ignored", out_q, 1);
    bus_wr(2'd3, 8'h50);
    chk("R10 control for channel 1 ignored", out_q, 1);
    bus_wr(2'd2, 8'h44);
    ticks(1);
    chk("R10 write to addr 2 ignored", out_q, 1);
    gate = 1'b0;
    bus_wr(2'd3, 8'h30);
    bus_wr(2'd0, 8'h03); bus_wr(2'd0, 8'h00);
    ticks(10);
    chk("R4 gate low pauses", out_q, 0);
    gate = 1'b1;
    ticks(2);
    chk("R4 resume before end", out_q, 0);
    ticks(1);
    chk("R4 resume reaches end", out_q, 1);
  endtask

  task automatic t_control_decode();
    bus_wr(2'd3, 8'h31);
    chk("R2 bcd bit ignored, mode 0", out_q, 0);
    bus_wr(2'd3, 8'h32);
    chk("R2 mode 001 ignored", out_q, 0);
    bus_wr(2'd0, 8'h10); bus_wr(2'd0, 8'h00);
    ticks(16);
    chk("R2 binary count 16 not done", out_q, 0);
    ticks(1);
    chk("R2 binary count 16 done", out_q, 1);
  endtask

  task automatic t_byte_access();
    logic [7:0] d;
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd0, 8'h07);
    ticks(7);
    chk("R3 low-only count 7 pending", out_q, 0);
    ticks(1);
    chk("R3 low-only count 7 done", out_q, 1);
    bus_wr(2'd3, 8'h20);
    bus_wr(2'd0, 8'h01);
    ticks(256);
    chk("R3 high-only count 256 pending", out_q, 0);
    ticks(1);
    chk("R3 high-only count 256 done", out_q, 1);
    bus_rd(2'd0, d);
    chk("R9 high byte read at zero", d, 8'h00);
    ticks(1);
    bus_rd(2'd0, d);
    chk("R3 wrap high byte", d, 8'hFF);
    bus_wr(2'd3, 8'h10);
    bus_wr(2'd0, 8'h00);
    ticks(2);
    bus_rd(2'd0, d);
    chk("R3 zero count wraps to FFFF", d, 8'hFF);
    chk("R3 zero count not expired", out_q, 0);
  endtask

  task automatic t_rate();
    logic [7:0] a, b, c, e;
    gate = 1'b1;
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd0, 8'h04); bus_wr(2'd0, 8'h00);
    for (int t = 1; t <= 12; t++) begin
      ticks(1);
      chk($sformatf("R5 rate N=4 tick %0d", t), out_q, ((t - 1) % 4 == 3) ? 0 : 1);
    end
    bus_wr(2'd0, 8'h06); bus_wr(2'd0, 8'h00);
    for (int t = 13; t <= 18; t++) begin
      ticks(1);
      chk($sformatf("R11 new count at reload tick %0d", t), out_q, (t == 18) ? 0 : 1);
    end
    gate = 1'b0;
    ticks(1);
    chk("R5 gate low forces high", out_q, 1);
    bus_rd(2'd0, a); bus_rd(2'd0, b);
    ticks(3);
    bus_rd(2'd0, c); bus_rd(2'd0, e);
    chk("R5 gate low holds count", {c, e}, {a, b});
    chk("R5 gate low still high", out_q, 1);
    gate = 1'b1;
  endtask

  task automatic t_square();
    bus_wr(2'd3, 8'h36);
    bus_wr(2'd0, 8'h05); bus_wr(2'd0, 8'h00);
    for (int t = 1; t <= 10; t++) begin
      ticks(1);
      chk($sformatf("R6 square N=5 tick %0d", t), out_q, ((t - 1) % 5 < 3) ? 1 : 0);
    end
    bus_wr(2'd3, 8'h36);
    bus_wr(2'd0, 8'h04); bus_wr(2'd0, 8'h00);
    for (int t = 1; t <= 8; t++) begin
      ticks(1);
      chk($sformatf("R6 square N=4 tick %0d", t), out_q, ((t - 1) % 4 < 2) ? 1 : 0);
    end
    gate = 1'b0;
    ticks(1);
    chk("R6 gate low forces high", out_q, 1);
    gate = 1'b1;
    bus_wr(2'd3, 8'h36);
    bus_wr(2'd0, 8'h88); bus_wr(2'd0, 8'h13);
    ticks(2500);
    chk("R6 5000 high half end", out_q, 1);
    ticks(1);
    chk("R6 5000 low half start", out_q, 0);
    ticks(2499);
    chk("R6 5000 low half end", out_q, 0);
    ticks(1);
    chk("R6 5000 next period", out_q, 1);
  endtask

  task automatic t_strobe();
    gate = 1'b0;
    bus_wr(2'd3, 8'h3A);
    chk("R7 out high after control", out_q, 1);
    bus_wr(2'd0, 8'h03); bus_wr(2'd0, 8'h00);
    ticks(5);
    chk("R7 no trigger no pulse", out_q, 1);
    gate = 1'b1;
    @(negedge clk); @(negedge clk);
    ticks(3);
    chk("R7 before expiry", out_q, 1);
    ticks(1);
    chk("R7 pulse at expiry", out_q, 0);
    ticks(1);
    chk("R7 pulse one tick", out_q, 1);
    ticks(10);
    chk("R7 once per trigger", out_q, 1);
    gate = 1'b0;
    @(negedge clk); @(negedge clk);
    gate = 1'b1;
    @(negedge clk); @(negedge clk);
    ticks(4);
    chk("R7 retrigger pulse", out_q, 0);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    gate = 1'b1;
    bus_wr(2'd3, 8'h34);
    bus_wr(2'd0, 8'hE8); bus_wr(2'd0, 8'h03);
    ticks(11);
    bus_wr(2'd3, 8'h00);
    ticks(5);
    bus_rd(2'd0, d);
    chk("R8 latched low byte", d, 8'hDE);
    ticks(2);
    bus_wr(2'd3, 8'h00);
    bus_rd(2'd0, d);
    chk("R8 latched high byte, relatch ignored", d, 8'h03);
    bus_rd(2'd0, d);
    chk("R9 live low byte", d, 8'hD7);
    bus_rd(2'd0, d);
    chk("R9 live high byte", d, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_term_count();
    t_control_decode();
    t_byte_access();
    t_rate();
    t_square();
    t_strobe();
    t_latch();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule